// File: doc/BRIEF.md
# Lookup-Table Fabric Evaluation Engine

This block evaluates a small programmable logic fabric in hardware, one cell at a time. Each cell is a 4-input lookup table paired with a register. The engine keeps three stores. The first is a flat data store of bits holding the input port area and, for every cell, a combinational entry and a registered entry. The second is a configuration store with one 64-bit word per cell. The third is a jump table of absolute data-store addresses. A cell operand is named by a 12-bit field. Small fields are signed offsets from the cell's own combinational entry. Large fields escape into the jump table, which reaches cells that are far away.

A controller loads the configuration and the jump table while the engine is idle. It then drives the input bits and pulses `start`. One iteration runs the following steps. The inputs are copied into the data store. The engine sweeps over all cells, writing each new value in place, and repeats the sweep until a full sweep changes nothing. If the emulated clock (input bit 0) rose since the previous settled iteration, every cell's combinational value is copied into its register. Finally the registered values of the first cells are published on the output port. If the fabric does not settle within a parameterised number of sweeps, the engine reports a convergence failure and leaves all registered state alone.

Top module: `lutfab_engine`

## Requirements
- R1: After reset `busy`, `settled`, `conv_fail` and `out_bits` are all zero.
- R2: A cell's combinational value is bit `{b3,b2,b1,b0}` of its 16-bit truth table, where bK is the bit fetched by operand field K. The configuration word holds the truth table in [15:0], field 0 in [27:16], field 1 in [39:28], field 2 in [51:40] and field 3 in [63:52].
- R3: Data store layout: input bit j sits at index j. Cell c has its combinational entry at IN_BITS+2c and its registered entry at IN_BITS+2c+1. A field below 0x800 addresses (own combinational index + field − 0x400). Any address outside the store reads as 0.
- R4: A field of 0x800 or above selects jump-table entry (field − 0x800), which holds an absolute data-store index. An entry beyond the table depth, or an index beyond the store, reads as 0.
- R5: An iteration loads `in_bits` and repeats full sweeps until one sweep changes no cell. It then raises `settled`. A cell that reads a cell later in the sweep order still reaches its settled value.
- R6: Registers take the combinational values only when input bit 0 is 1 and was 0 at the previous settled iteration. An iteration where bit 0 stays 0 or stays 1 leaves all registers unchanged.
- R7: At the end of every iteration `out_bits[k]` becomes the registered entry of cell k. While idle it does not change.
- R8: If MAX_PASS sweeps all change some cell, `conv_fail` rises and `settled` stays low. No register changes, and the emulated-clock history is kept, so a rising clock is still seen by the next settled iteration.
- R9: `start` while idle raises `busy` on the next cycle and clears both flags. `busy` falls within NCELL*MAX_PASS+8 cycles.
- R10: `settled` and `conv_fail` are never high together, and one of them is high when `busy` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Engine clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration word write strobe (idle only) |
| cfg_cell | input | $clog2(NCELL) | Cell whose configuration is written |
| cfg_word | input | 64 | Configuration word: truth table and four operand fields |
| jt_we | input | 1 | Jump-table write strobe (idle only) |
| jt_sel | input | $clog2(JT_DEPTH) | Jump-table entry written |
| jt_addr | input | 12 | Absolute data-store index for that entry |
| in_bits | input | IN_BITS | Input port bits; bit 0 is the emulated clock |
| start | input | 1 | Begin one iteration |
| busy | output | 1 | Iteration in progress |
| settled | output | 1 | Last iteration reached a fixed point |
| conv_fail | output | 1 | Last iteration ran out of sweeps |
| out_bits | output | OUT_BITS | Registered values of cells 0 .. OUT_BITS-1 |

## Verification
The fixed test fabric mixes several kinds of cell. There is an AND gate and an XOR fed by it, a buffer that captures the XOR, and a toggle cell that reads its own register. One cell is fed through the jump table, two deliberately read out-of-range sources, and one reads a cell later in the sweep order. Eight input patterns are each applied with the clock low and then high. The low phase shows that registers hold, and the high phase shows that each gate, the toggle parity and the forward reference reach their expected values. Directed cases cover several behaviours: a clock held high, a self-inverting ring that forces a convergence failure and is then repaired to show that the pending edge survives, and a single-minterm truth table that pins down the order of the four operand bits.

// File: rtl/lutfab_pkg.sv
package lutfab_pkg;
  typedef logic [11:0] fld_t;

  localparam fld_t REL_CENTER = 12'h400;
  localparam fld_t JUMP_ESC   = 12'h800;

  typedef struct packed {
    fld_t        src3;
    fld_t        src2;
    fld_t        src1;
    fld_t        src0;
    logic [15:0] truth;
  } cell_cfg_t;

  typedef enum logic [2:0] {
    EV_IDLE,
    EV_LOAD,
    EV_PASS,
    EV_CLOCK,
    EV_PUBLISH
  } ev_state_t;
endpackage

// File: rtl/lutfab_rst_sync.sv
module lutfab_rst_sync (
  input  logic clk,
  input  logic rst_n_a,
  output logic rst_n_s
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_a) begin
    if (!rst_n_a) sync_q <= '0;
    else          sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_s = sync_q[1];
endmodule

// File: rtl/lutfab_src_resolve.sv
module lutfab_src_resolve
  import lutfab_pkg::*;
#(
  parameter int DATA_W   = 72,
  parameter int AW       = 7,
  parameter int JT_DEPTH = 16,
  parameter int JW       = 4
) (
  input  fld_t            fld,
  input  logic [AW-1:0]   home,
  input  fld_t            jt_tab [JT_DEPTH],
  output logic            ok,
  output logic [AW-1:0]   idx
);
  always_comb begin
    int   rel;
    int   pick;
    fld_t esc;
    ok   = 1'b0;
    idx  = '0;
    rel  = 0;
    pick = 0;
    esc  = fld - JUMP_ESC;
    if (fld < JUMP_ESC) begin
      rel = int'(home) + int'(fld) - int'(REL_CENTER);
      if (rel >= 0 && rel < DATA_W) begin
        ok  = 1'b1;
        idx = AW'(rel);
      end
    end else if (int'(esc) < JT_DEPTH) begin
      pick = int'(jt_tab[esc[JW-1:0]]);
      if (pick < DATA_W) begin
        ok  = 1'b1;
        idx = AW'(pick);
      end
    end
  end
endmodule

// File: rtl/lutfab_lut4.sv
module lutfab_lut4 (
  input  logic [15:0] truth,
  input  logic [3:0]  sel,
  output logic        y
);
  assign y = truth[sel];
endmodule

// File: rtl/lutfab_engine.sv
module lutfab_engine
  import lutfab_pkg::*;
#(
  parameter int NCELL    = 32,
  parameter int IN_BITS  = 8,
  parameter int OUT_BITS = 8,
  parameter int JT_DEPTH = 16,
  parameter int MAX_PASS = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cfg_we,
  input  logic [$clog2(NCELL)-1:0]    cfg_cell,
  input  logic [63:0]                 cfg_word,
  input  logic                        jt_we,
  input  logic [$clog2(JT_DEPTH)-1:0] jt_sel,
  input  logic [11:0]                 jt_addr,
  input  logic [IN_BITS-1:0]          in_bits,
  input  logic                        start,
  output logic                        busy,
  output logic                        settled,
  output logic                        conv_fail,
  output logic [OUT_BITS-1:0]         out_bits
);
  localparam int BASE   = IN_BITS;
  localparam int DATA_W = BASE + 2 * NCELL;
  localparam int AW     = $clog2(DATA_W);
  localparam int CW     = $clog2(NCELL);
  localparam int JW     = $clog2(JT_DEPTH);
  localparam int PW     = $clog2(MAX_PASS + 1);

  logic rst_ni;

  lutfab_rst_sync u_rst (
    .clk     (clk),
    .rst_n_a (rst_n),
    .rst_n_s (rst_ni)
  );

  // state
  ev_state_t           st_q, st_d;
  logic [DATA_W-1:0]   dat_q, dat_d;
  logic [CW-1:0]       cell_q, cell_d;
  logic [PW-1:0]       pass_q, pass_d;
  logic                chg_q, chg_d;
  logic                prev_clk_q, prev_clk_d;
  logic                settled_q, settled_d;
  logic                fail_q, fail_d;
  logic [OUT_BITS-1:0] out_q, out_d;

  cell_cfg_t           cfg_q [NCELL];
  fld_t                jt_q  [JT_DEPTH];

  logic cfg_wr_en;
  logic jt_wr_en;

  assign cfg_wr_en = cfg_we && (st_q == EV_IDLE);
  assign jt_wr_en  = jt_we  && (st_q == EV_IDLE);

  // configuration and jump-table stores
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NCELL; i++) cfg_q[i] <= '0;
    end else if (cfg_wr_en) begin
      cfg_q[cfg_cell] <= cell_cfg_t'(cfg_word);
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < JT_DEPTH; i++) jt_q[i] <= '0;
    end else if (jt_wr_en) begin
      jt_q[jt_sel] <= jt_addr;
    end
  end

  // current cell operand fetch
  cell_cfg_t     cur;
  logic [AW-1:0] home;
  fld_t          src     [4];
  logic [3:0]    src_ok;
  logic [AW-1:0] src_idx [4];
  logic [3:0]    sel;
  logic          lut_y;

  assign cur    = cfg_q[cell_q];
  assign home   = AW'(BASE) + AW'({cell_q, 1'b0});
  assign src[0] = cur.src0;
  assign src[1] = cur.src1;
  assign src[2] = cur.src2;
  assign src[3] = cur.src3;

  generate
    for (genvar k = 0; k < 4; k++) begin : g_src
      lutfab_src_resolve #(
        .DATA_W   (DATA_W),
        .AW       (AW),
        .JT_DEPTH (JT_DEPTH),
        .JW       (JW)
      ) u_res (
        .fld    (src[k]),
        .home   (home),
        .jt_tab (jt_q),
        .ok     (src_ok[k]),
        .idx    (src_idx[k])
      );
      assign sel[k] = src_ok[k] & dat_q[src_idx[k]];
    end
  endgenerate

  lutfab_lut4 u_lut (
    .truth (cur.truth),
    .sel   (sel),
    .y     (lut_y)
  );

  // next-state
  always_comb begin
    logic chg_now;
    st_d       = st_q;
    dat_d      = dat_q;
    cell_d     = cell_q;
    pass_d     = pass_q;
    chg_d      = chg_q;
    prev_clk_d = prev_clk_q;
    settled_d  = settled_q;
    fail_d     = fail_q;
    out_d      = out_q;
    chg_now    = chg_q | (lut_y != dat_q[home]);
    unique case (st_q)
      EV_IDLE: begin
        if (start) begin
          st_d      = EV_LOAD;
          settled_d = 1'b0;
          fail_d    = 1'b0;
        end
      end
      EV_LOAD: begin
        dat_d[IN_BITS-1:0] = in_bits;
        cell_d = '0;
        pass_d = '0;
        chg_d  = 1'b0;
        st_d   = EV_PASS;
      end
      EV_PASS: begin
        dat_d[home] = lut_y;
        if (cell_q == CW'(NCELL - 1)) begin
          if (!chg_now) begin
            settled_d = 1'b1;
            st_d      = EV_CLOCK;
          end else if (pass_q == PW'(MAX_PASS - 1)) begin
            fail_d = 1'b1;
            st_d   = EV_CLOCK;
          end else begin
            pass_d = pass_q + 1'b1;
            cell_d = '0;
            chg_d  = 1'b0;
          end
        end else begin
          cell_d = cell_q + 1'b1;
          chg_d  = chg_now;
        end
      end
      EV_CLOCK: begin
        if (settled_q) begin
          prev_clk_d = dat_q[0];
          if (dat_q[0] && !prev_clk_q) begin
            for (int c = 0; c < NCELL; c++) dat_d[BASE + 2*c + 1] = dat_q[BASE + 2*c];
          end
        end
        st_d = EV_PUBLISH;
      end
      EV_PUBLISH: begin
        for (int k = 0; k < OUT_BITS; k++) out_d[k] = dat_q[BASE + 2*k + 1];
        st_d = EV_IDLE;
      end
      default: st_d = EV_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= EV_IDLE;
      dat_q      <= '0;
      cell_q     <= '0;
      pass_q     <= '0;
      chg_q      <= 1'b0;
      prev_clk_q <= 1'b0;
      settled_q  <= 1'b0;
      fail_q     <= 1'b0;
      out_q      <= '0;
    end else begin
      st_q       <= st_d;
      dat_q      <= dat_d;
      cell_q     <= cell_d;
      pass_q     <= pass_d;
      chg_q      <= chg_d;
      prev_clk_q <= prev_clk_d;
      settled_q  <= settled_d;
      fail_q     <= fail_d;
      out_q      <= out_d;
    end
  end

  assign busy      = (st_q != EV_IDLE);
  assign settled   = settled_q;
  assign conv_fail = fail_q;
  assign out_bits  = out_q;
endmodule

// File: rtl/lutfab_engine_chk.sv
module lutfab_engine_chk #(
  parameter int NCELL    = 32,
  parameter int MAX_PASS = 8,
  parameter int OUT_BITS = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                start,
  input logic                busy,
  input logic                settled,
  input logic                conv_fail,
  input logic [OUT_BITS-1:0] out_bits
);
  localparam int LIMIT = NCELL * MAX_PASS + 8;

  logic [31:0] busy_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_run <= '0;
    else if (busy) busy_run <= busy_run + 1'b1;
    else           busy_run <= '0;
  end

  // R10
  flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(settled && conv_fail));

  // R10
  end_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (settled || conv_fail));

  // R9
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  // R9
  start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (!settled && !conv_fail));

  // R9
  busy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_run <= LIMIT);

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(out_bits));
endmodule

bind lutfab_engine lutfab_engine_chk #(
  .NCELL    (NCELL),
  .MAX_PASS (MAX_PASS),
  .OUT_BITS (OUT_BITS)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .busy      (busy),
  .settled   (settled),
  .conv_fail (conv_fail),
  .out_bits  (out_bits)
);

// File: tb/lutfab_engine_tb_top.sv
module lutfab_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [4:0]  cfg_cell;
  logic [63:0] cfg_word;
  logic        jt_we;
  logic [3:0]  jt_sel;
  logic [11:0] jt_addr;
  logic [7:0]  in_bits;
  logic        start;
  logic        busy;
  logic        settled;
  logic        conv_fail;
  logic [7:0]  out_bits;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  lutfab_engine dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_cell  (cfg_cell),
    .cfg_word  (cfg_word),
    .jt_we     (jt_we),
    .jt_sel    (jt_sel),
    .jt_addr   (jt_addr),
    .in_bits   (in_bits),
    .start     (start),
    .busy      (busy),
    .settled   (settled),
    .conv_fail (conv_fail),
    .out_bits  (out_bits)
  );

  // stimulus {in5..in1} and expected out_bits after a rising emulated clock
  localparam logic [12:0] VEC [8] = '{
    {5'b00000, 8'h68},
    {5'b00011, 8'h67},
    {5'b00111, 8'h69},
    {5'b00100, 8'h66},
    {5'b01000, 8'h78},
    {5'b10000, 8'hE0},
    {5'b11101, 8'hFE},
    {5'b11111, 8'hF1}
  };

  function automatic int ci(int c);
    return 8 + 2 * c;
  endfunction

  function automatic logic [11:0] rel(int from_idx, int to_idx);
    return 12'(to_idx - from_idx + 1024);
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic put_cell(input int c, input logic [15:0] tt, input logic [11:0] a0,
                          input logic [11:0] a1, input logic [11:0] a2, input logic [11:0] a3);
    @(negedge clk);
    cfg_we   = 1'b1;
    cfg_cell = 5'(c);
    cfg_word = {a3, a2, a1, a0, tt};
    @(negedge clk);
    cfg_we   = 1'b0;
  endtask

  task automatic put_jump(input int e, input logic [11:0] a);
    @(negedge clk);
    jt_we   = 1'b1;
    jt_sel  = 4'(e);
    jt_addr = a;
    @(negedge clk);
    jt_we   = 1'b0;
  endtask

  task automatic run_iter(input logic [4:0] s, input logic clk_bit);
    @(negedge clk);
    in_bits = {2'b00, s, clk_bit};
    start   = 1'b1;
    @(negedge clk);
    start   = 1'b0;
    chk("R9 busy after start", 32'(busy), 32'd1);
    while (busy) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] prev;
    rst_n    = 1'b0;
    cfg_we   = 1'b0;
    cfg_cell = '0;
    cfg_word = '0;
    jt_we    = 1'b0;
    jt_sel   = '0;
    jt_addr  = '0;
    in_bits  = '0;
    start    = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1 busy", 32'(busy), 32'd0);
    chk("R1 settled", 32'(settled), 32'd0);
    chk("R1 conv_fail", 32'(conv_fail), 32'd0);
    chk("R1 out_bits", 32'(out_bits), 32'd0);

    // test fabric
    put_jump(0, 12'd4);
    put_jump(1, 12'd100);
    put_cell(0, 16'h8888, rel(ci(0), 1), rel(ci(0), 2), 12'h000, 12'h000);
    put_cell(1, 16'h6666, rel(ci(1), 3), rel(ci(1), ci(0)), 12'h000, 12'h000);
    put_cell(2, 16'hAAAA, rel(ci(2), ci(1)), 12'h000, 12'h000, 12'h000);
    put_cell(3, 16'h5555, rel(ci(3), ci(3) + 1), 12'h000, 12'h000, 12'h000);
    put_cell(4, 16'hAAAA, 12'h800, 12'h000, 12'h000, 12'h000);
    put_cell(5, 16'h0001, 12'h801, 12'hFFF, 12'h000, 12'h000);
    put_cell(6, 16'h0001, 12'h000, 12'h000, 12'h000, 12'h000);
    put_cell(7, 16'hAAAA, rel(ci(7), ci(8)), 12'h000, 12'h000, 12'h000);
    put_cell(8, 16'hAAAA, rel(ci(8), 5), 12'h000, 12'h000, 12'h000);

    // vector table: R2 R3 R4 R5 R6 R7
    prev = 8'h00;
    for (int i = 0; i < 8; i++) begin
      run_iter(VEC[i][12:8], 1'b0);
      chk("R6 no capture with clock low", 32'(out_bits), 32'(prev));
      chk("R5 settled", 32'(settled), 32'd1);
      run_iter(VEC[i][12:8], 1'b1);
      chk("R7 R2 R3 R4 R5 outputs after edge", 32'(out_bits), 32'(VEC[i][7:0]));
      chk("R10 no failure flag", 32'(conv_fail), 32'd0);
      prev = VEC[i][7:0];
    end

    // R6 clock held high: no capture
    run_iter(5'b00000, 1'b1);
    chk("R6 clock held high", 32'(out_bits), 32'hF1);

    // R7 idle stability under changing inputs
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      in_bits = 8'(i * 37 + 5);
    end
    chk("R7 idle hold", 32'(out_bits), 32'hF1);

    // R8 convergence failure keeps registers and clock history
    run_iter(5'b00000, 1'b0);
    chk("R6 low phase", 32'(out_bits), 32'hF1);
    put_cell(9, 16'h5555, 12'h400, 12'h400, 12'h400, 12'h400);
    run_iter(5'b00000, 1'b1);
    chk("R8 conv_fail", 32'(conv_fail), 32'd1);
    chk("R8 settled low", 32'(settled), 32'd0);
    chk("R8 registers untouched", 32'(out_bits), 32'hF1);
    put_cell(9, 16'h0000, 12'h000, 12'h000, 12'h000, 12'h000);
    run_iter(5'b00000, 1'b1);
    chk("R8 settled after repair", 32'(settled), 32'd1);
    chk("R8 pending edge taken", 32'(out_bits), 32'h68);

    // R2 operand order: single minterm at index 10
    put_cell(6, 16'h0400, rel(ci(6), 1), rel(ci(6), 2), rel(ci(6), 3), rel(ci(6), 4));
    run_iter(5'b01010, 1'b0);
    run_iter(5'b01010, 1'b1);
    chk("R2 minterm 1010 selected", 32'(out_bits[6]), 32'd1);
    run_iter(5'b00101, 1'b0);
    run_iter(5'b00101, 1'b1);
    chk("R2 index 0101 clear", 32'(out_bits[6]), 32'd0);
    run_iter(5'b01011, 1'b0);
    run_iter(5'b01011, 1'b1);
    chk("R2 index 1011 clear", 32'(out_bits[6]), 32'd0);

    finish_run();
  end
endmodule